// File: doc/BRIEF.md
# Chained Memory-to-Memory DMA Engine

This block copies blocks of words from one region of a flat memory to another on behalf of software. Each job is a four-word descriptor in memory. The first word is control, with the ownership flag in its top bit. The next three words are the source address, the destination address and the word count. The engine reads a descriptor, then moves the data through a small internal FIFO. It reads from the source until the FIFO is full or the count is used up, then writes the FIFO out to the destination. It repeats this until the count reaches zero. It then hands the descriptor back to software and moves on to the next one, which lies directly after it.

Software controls progress with two things. The engine only fetches a descriptor while a ready flag is set, and the engine clears that flag itself. It only runs a descriptor whose ownership flag marks it as owned by the engine. A sticky interrupt reports each finished descriptor. Clearing the enable bit in the middle of a job can also report the job as failed.

The register port uses word offsets and bit positions that software and the bench rely on:

| Offset | Contents |
|---|---|
| 0 (control) | bit0 enable; bit7 FIFO flush, write-only, reads 0; bit8 error-interrupt enable; bits10:9 FIFO status; bit11 error status |
| 1 | descriptor pointer |
| 2 | ready flag, bit0 |
| 3 | source copy |
| 4 | destination copy |
| 5 | count copy |
| 6 | interrupt flag, bit0 |

Top module: `mdma_engine`

## Requirements
- R1: After reset, the interrupt output is low, the control register and the ready register read 0, and the engine makes no memory request.
- R2: When enable is set and the ready flag is clear, the engine issues no memory request until software sets the ready flag.
- R3: A descriptor is read from four consecutive words at the pointer (control, source, destination, count). The source, destination and count then read back from offsets 3, 4 and 5. Software may rewrite the pointer while the engine is idle or waiting for the ready flag.
- R4: If the control word read at the pointer has bit 15 clear, the engine reads no further word of that descriptor and makes no write. It clears the ready flag. It fetches the same pointer again once ready is set again.
- R5: The destination receives exactly count words, equal to the source words and in the same order. Before any write, up to four words are read into the FIFO: the first write follows exactly min(4, count) data reads. No word past destination+count is touched.
- R6: After the last data write, the engine writes the descriptor's control word back to the pointer address with bit 15 cleared. The pointer then reads as the old pointer plus 4.
- R7: Finishing a descriptor sets the interrupt. The interrupt stays set until software writes 1 to bit 0 of offset 6.
- R8: A descriptor with a count of zero sets the interrupt and advances the pointer by 4. It makes no data access and no write-back.
- R9: Clearing enable during a transfer, with the error-interrupt enable set, stops all memory traffic. It raises the interrupt and sets the error status bit (bit 11).
- R10: Writing 1 to control bit 7 empties the FIFO, so the FIFO status field (bits 10:9) reads 00.
- R11: The FIFO status field reads 11 while the FIFO holds at least one word, for example after a transfer is cut short.
- R12: The ready flag reads 0 once the data transfer of a descriptor has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr (combinational) |
| mem_req | output | 1 | Memory access request, always accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| done_irq | output | 1 | Sticky interrupt |

## Verification
The assertions assume two things about the memory:
- It accepts every request in the cycle it is made.
- It returns read data exactly one cycle later.

The bench memory model keeps to both. The assertions also assume that software never asks for a push into a full FIFO. The bench keeps to this because the FIFO is only written by the engine itself, and the bench reaches the FIFO only through the flush bit. Descriptors, source data and counts from 1 to 12 come from a seeded random generator. All of them are placed in memory regions that never overlap, so the words the bench expects are never disturbed by the transfer under test.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_FETCH = 3'd2,
        ST_READ  = 3'd3,
        ST_DRAIN = 3'd4,
        ST_CLOSE = 3'd5
    } mdma_state_e;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_PTR   = 3'd1;
    localparam logic [2:0] REG_READY = 3'd2;
    localparam logic [2:0] REG_SRC   = 3'd3;
    localparam logic [2:0] REG_DST   = 3'd4;
    localparam logic [2:0] REG_CNT   = 3'd5;
    localparam logic [2:0] REG_IRQ   = 3'd6;

    localparam int BIT_EN    = 0;
    localparam int BIT_FLUSH = 7;
    localparam int BIT_ERRIE = 8;
    localparam int BIT_FS_LO = 9;
    localparam int BIT_FS_HI = 10;
    localparam int BIT_ERRST = 11;

    localparam int DESC_WORDS = 4;

endpackage

// File: rtl/mdma_fifo.sv
module mdma_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          flush_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] store;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_s;

    fifo_s q, d;

    always_comb begin
        d = q;
        if (flush_i) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (push_i) begin
                d.store[q.wp] = wdata_i;
                d.wp = (q.wp == LAST) ? '0 : q.wp + PW'(1);
            end
            if (pop_i) begin
                d.rp = (q.rp == LAST) ? '0 : q.rp + PW'(1);
            end
            d.cnt = q.cnt + CW'(push_i) - CW'(pop_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_o = q.store[q.rp];
    assign full_o  = (q.cnt == CW'(DEPTH));
    assign empty_o = (q.cnt == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i) |-> (!full_o || pop_i));                      // R5
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i) |-> !empty_o);                                  // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);                                               // R10

endmodule

// File: rtl/mdma_core.sv
module mdma_core
    import mdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_i,
    input  logic [2:0]    reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          f_push_o,
    output logic          f_pop_o,
    output logic          f_flush_o,
    output logic [DW-1:0] f_wdata_o,
    input  logic [DW-1:0] f_rdata_i,
    input  logic          f_full_i,
    input  logic          f_empty_i,
    output logic          irq_o
);
    localparam logic [DW-1:0] OWN_MASK = {1'b1, {(DW-1){1'b0}}};
    localparam logic [AW-1:0] DESC_STEP = AW'(DESC_WORDS);

    typedef struct packed {
        mdma_state_e   st;
        logic [AW-1:0] ptr;
        logic          en;
        logic          errie;
        logic          errst;
        logic          irq;
        logic          ready;
        logic          pend;
        logic [1:0]    idx;
        logic [DW-1:0] dctl;
        logic [DW-1:0] dsrc;
        logic [DW-1:0] ddst;
        logic [DW-1:0] dcnt;
        logic [DW-1:0] rem;
        logic [AW-1:0] rsrc;
        logic [AW-1:0] rdst;
    } core_s;

    core_s q, d;
    logic  busy, irq_set, irq_clr;

    assign busy      = q.st inside {ST_FETCH, ST_READ, ST_DRAIN, ST_CLOSE};
    assign f_wdata_o = mem_rdata_i;

    always_comb begin
        d           = q;
        irq_set     = 1'b0;
        irq_clr     = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        f_push_o    = 1'b0;
        f_pop_o     = 1'b0;
        f_flush_o   = 1'b0;

        if (busy && !q.en) begin
            d.st   = ST_IDLE;
            d.pend = 1'b0;
            if (q.errie) begin
                d.errst = 1'b1;
                irq_set = 1'b1;
            end
        end else begin
            case (q.st)
                ST_IDLE: ;
                ST_WAIT: begin
                    if (!q.en) d.st = ST_IDLE;
                    else if (q.ready) begin
                        d.st   = ST_FETCH;
                        d.idx  = 2'd0;
                        d.pend = 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (!q.pend) begin
                        mem_req_o  = 1'b1;
                        mem_addr_o = q.ptr + AW'(q.idx);
                        d.pend     = 1'b1;
                    end else begin
                        d.pend = 1'b0;
                        d.idx  = q.idx + 2'd1;
                        case (q.idx)
                            2'd0: begin
                                d.dctl = mem_rdata_i;
                                if (!mem_rdata_i[DW-1]) begin
                                    d.ready = 1'b0;
                                    d.st    = ST_WAIT;
                                end
                            end
                            2'd1: d.dsrc = mem_rdata_i;
                            2'd2: d.ddst = mem_rdata_i;
                            default: begin
                                d.dcnt  = mem_rdata_i;
                                d.ready = 1'b0;
                                if (mem_rdata_i == '0) begin
                                    irq_set = 1'b1;
                                    d.ptr   = q.ptr + DESC_STEP;
                                    d.st    = ST_WAIT;
                                end else begin
                                    d.rsrc = AW'(q.dsrc);
                                    d.rdst = AW'(q.ddst);
                                    d.rem  = mem_rdata_i;
                                    d.st   = ST_READ;
                                end
                            end
                        endcase
                    end
                end
                ST_READ: begin
                    if (!q.pend) begin
                        if (f_full_i || q.rem == '0) d.st = ST_DRAIN;
                        else begin
                            mem_req_o  = 1'b1;
                            mem_addr_o = q.rsrc;
                            d.pend     = 1'b1;
                        end
                    end else begin
                        f_push_o = 1'b1;
                        d.rsrc   = q.rsrc + AW'(1);
                        d.rem    = q.rem - DW'(1);
                        d.pend   = 1'b0;
                    end
                end
                ST_DRAIN: begin
                    if (f_empty_i) d.st = (q.rem == '0) ? ST_CLOSE : ST_READ;
                    else begin
                        mem_req_o   = 1'b1;
                        mem_we_o    = 1'b1;
                        mem_addr_o  = q.rdst;
                        mem_wdata_o = f_rdata_i;
                        f_pop_o     = 1'b1;
                        d.rdst      = q.rdst + AW'(1);
                    end
                end
                ST_CLOSE: begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = q.ptr;
                    mem_wdata_o = q.dctl & ~OWN_MASK;
                    irq_set     = 1'b1;
                    d.ptr       = q.ptr + DESC_STEP;
                    d.st        = ST_WAIT;
                end
                default: d.st = ST_IDLE;
            endcase
        end

        if (reg_wr_i) begin
            case (reg_addr_i)
                REG_CTRL: begin
                    d.en      = reg_wdata_i[BIT_EN];
                    d.errie   = reg_wdata_i[BIT_ERRIE];
                    f_flush_o = reg_wdata_i[BIT_FLUSH];
                    if (reg_wdata_i[BIT_EN] && !q.en) begin
                        d.errst = 1'b0;
                        if (q.st == ST_IDLE) d.st = ST_WAIT;
                    end
                end
                REG_PTR:   if (q.st == ST_IDLE || q.st == ST_WAIT) d.ptr = AW'(reg_wdata_i);
                REG_READY: d.ready = reg_wdata_i[0];
                REG_IRQ:   irq_clr = reg_wdata_i[0];
                default: ;
            endcase
        end
        d.irq = (q.irq & ~irq_clr) | irq_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            REG_CTRL: begin
                reg_rdata_o[BIT_EN]              = q.en;
                reg_rdata_o[BIT_ERRIE]           = q.errie;
                reg_rdata_o[BIT_FS_HI:BIT_FS_LO] = {2{!f_empty_i}};
                reg_rdata_o[BIT_ERRST]           = q.errst;
            end
            REG_PTR:   reg_rdata_o = DW'(q.ptr);
            REG_READY: reg_rdata_o[0] = q.ready;
            REG_SRC:   reg_rdata_o = q.dsrc;
            REG_DST:   reg_rdata_o = q.ddst;
            REG_CNT:   reg_rdata_o = q.dcnt;
            REG_IRQ:   reg_rdata_o[0] = q.irq;
            default: ;
        endcase
    end

    assign irq_o = q.irq;

    AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && !q.ready) |=> !mem_req_o);                                     // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(reg_wr_i && reg_addr_i == REG_IRQ && reg_wdata_i[0])) |=> irq_o);      // R7
    AST_DRAIN_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && q.st == ST_DRAIN) |-> !f_empty_i);                       // R5
    AST_DISOWNED_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && q.pend && q.idx == 2'd0 && !mem_rdata_i[DW-1] && q.en
         && !(reg_wr_i && reg_addr_i == REG_READY)) |=> (q.st == ST_WAIT && !q.ready));    // R4
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q.en) |=> !mem_req_o);                                                   // R9

endmodule

// File: rtl/mdma_engine.sv
module mdma_engine #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done_irq
);
    logic          f_push, f_pop, f_flush, f_full, f_empty;
    logic [DW-1:0] f_wdata, f_rdata;

    mdma_core #(.AW(AW), .DW(DW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (cfg_wr),
        .reg_addr_i  (cfg_addr),
        .reg_wdata_i (cfg_wdata),
        .reg_rdata_o (cfg_rdata),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .f_push_o    (f_push),
        .f_pop_o     (f_pop),
        .f_flush_o   (f_flush),
        .f_wdata_o   (f_wdata),
        .f_rdata_i   (f_rdata),
        .f_full_i    (f_full),
        .f_empty_i   (f_empty),
        .irq_o       (done_irq)
    );

    mdma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (f_push),
        .pop_i   (f_pop),
        .flush_i (f_flush),
        .wdata_i (f_wdata),
        .rdata_o (f_rdata),
        .full_o  (f_full),
        .empty_o (f_empty)
    );

endmodule

// File: tb/mdma_engine_bench.sv
module mdma_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        done_irq;

    always #10 clk = ~clk;

    mdma_engine u_mdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done_irq(done_irq)
    );

    logic [15:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_a = '0;
    logic [15:0] tb_d = '0;
    int rd_cnt = 0, wr_cnt = 0, rw_ev = 0;
    int rw_log [0:7];
    bit last_rd = 1'b0;

    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt++;
                if (last_rd) begin
                    rw_log[rw_ev % 8] = rd_cnt;
                    rw_ev++;
                end
                last_rd = 1'b0;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_cnt++;
                last_rd = 1'b1;
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] wb_word(logic [15:0] ctl);
        return ctl & 16'h7FFF;
    endfunction

    function automatic logic [15:0] fs_field(logic [15:0] ctrl);
        return {14'd0, ctrl[10:9]};
    endfunction

    task automatic reg_w(logic [2:0] a, logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_r(logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic poke(logic [7:0] a, logic [15:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_a = a; tb_d = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(logic [7:0] b, logic [15:0] c, logic [15:0] s, logic [15:0] t, logic [15:0] n);
        poke(b, c); poke(b + 8'd1, s); poke(b + 8'd2, t); poke(b + 8'd3, n);
    endtask

    task automatic wait_irq(string tag);
        int n = 0;
        while (!done_irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, int'(done_irq), 1);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] exp_w [0:15];
        int rb, wb, eb;
        void'($urandom(32'd1234));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 irq", int'(done_irq), 0);
        reg_r(3'd0, v); chk("R1 ctrl", v, 0);
        reg_r(3'd2, v); chk("R1 ready", v, 0);
        chk("R1 no traffic", rd_cnt + wr_cnt, 0);

        // Directed transfer of 6 words
        for (int i = 0; i < 6; i++) begin
            exp_w[i] = 16'h1000 + 16'(i * 37);
            poke(8'h40 + 8'(i), exp_w[i]);
        end
        poke(8'h86, 16'hDEAD);
        put_desc(8'h10, 16'h8A5C, 16'h0040, 16'h0080, 16'd6);
        reg_w(3'd1, 16'h0010);
        reg_w(3'd0, 16'h0001);
        rb = rd_cnt;
        repeat (20) @(negedge clk);
        chk("R2 stall without ready", rd_cnt - rb, 0);

        eb = rw_ev;
        reg_w(3'd2, 16'h0001);
        wait_irq("R7 irq on done");
        for (int i = 0; i < 6; i++) chk("R5 data", mem[8'h80 + 8'(i)], exp_w[i]);
        chk("R5 no overrun", mem[8'h86], 16'hDEAD);
        chk("R5 first fill", rw_log[eb % 8], rb + 8);
        chk("R5 second fill", rw_log[(eb + 1) % 8], rb + 10);
        chk("R6 writeback", mem[8'h10], wb_word(16'h8A5C));
        reg_r(3'd1, v); chk("R6 next ptr", v, 16'h0014);
        reg_r(3'd3, v); chk("R3 src copy", v, 16'h0040);
        reg_r(3'd4, v); chk("R3 dst copy", v, 16'h0080);
        reg_r(3'd5, v); chk("R3 cnt copy", v, 16'd6);
        reg_r(3'd2, v); chk("R12 ready cleared", v, 0);
        repeat (10) @(negedge clk);
        chk("R7 sticky", int'(done_irq), 1);
        reg_w(3'd6, 16'h0001);
        @(negedge clk);
        chk("R7 cleared", int'(done_irq), 0);

        // R4 descriptor owned by software
        put_desc(8'h14, 16'h0003, 16'h0040, 16'h0090, 16'd2);
        rb = rd_cnt; wb = wr_cnt;
        reg_w(3'd2, 16'h0001);
        repeat (20) @(negedge clk);
        chk("R4 one read", rd_cnt - rb, 1);
        chk("R4 no write", wr_cnt - wb, 0);
        reg_r(3'd2, v); chk("R4 ready cleared", v, 0);
        chk("R4 no irq", int'(done_irq), 0);

        // R8 zero count, same pointer refetched
        poke(8'h14, 16'h8001);
        poke(8'h17, 16'h0000);
        rb = rd_cnt;
        reg_w(3'd2, 16'h0001);
        wait_irq("R8 irq");
        repeat (2) @(negedge clk);
        chk("R4 refetch reads", rd_cnt - rb, 4);
        chk("R8 no write", wr_cnt - wb, 0);
        chk("R8 no writeback", mem[8'h14], 16'h8001);
        reg_r(3'd1, v); chk("R8 ptr advance", v, 16'h0018);
        reg_w(3'd6, 16'h0001);

        // Random transfers with pointer rewrite
        for (int it = 0; it < 6; it++) begin
            int n;
            logic [7:0] b;
            logic [15:0] c;
            n = $urandom_range(12, 1);
            b = 8'h20 + 8'(it * 4);
            c = 16'h8000 | 16'($urandom_range(16'h7FFF, 0));
            for (int i = 0; i < n; i++) begin
                exp_w[i] = 16'($urandom);
                poke(8'h40 + 8'(i), exp_w[i]);
            end
            poke(8'hA0 + 8'(n), 16'hBEEF);
            put_desc(b, c, 16'h0040, 16'h00A0, 16'(n));
            reg_w(3'd1, {8'h00, b});
            reg_w(3'd2, 16'h0001);
            wait_irq("R7 random irq");
            for (int i = 0; i < n; i++) chk("R5 random data", mem[8'hA0 + 8'(i)], exp_w[i]);
            chk("R5 random no overrun", mem[8'hA0 + 8'(n)], 16'hBEEF);
            chk("R6 random writeback", mem[b], wb_word(c));
            reg_r(3'd5, v); chk("R3 random cnt", v, n);
            reg_w(3'd6, 16'h0001);
        end

        // R9 abort mid-transfer, R11 / R10 FIFO status and flush
        put_desc(8'h38, 16'h8000, 16'h0040, 16'h0090, 16'd12);
        reg_w(3'd1, 16'h0038);
        reg_w(3'd0, 16'h0101);
        rb = rd_cnt; wb = wr_cnt;
        reg_w(3'd2, 16'h0001);
        begin
            int n = 0;
            while (rd_cnt - rb < 6 && n < 200) begin
                @(negedge clk);
                n++;
            end
        end
        reg_w(3'd0, 16'h0100);
        repeat (2) @(negedge clk);
        rb = rd_cnt;
        chk("R9 irq", int'(done_irq), 1);
        reg_r(3'd0, v);
        chk("R9 error bit", int'(v[11]), 1);
        chk("R11 fifo status", fs_field(v), 3);
        chk("R9 no writes", wr_cnt - wb, 0);
        repeat (10) @(negedge clk);
        chk("R9 traffic stopped", rd_cnt - rb, 0);
        reg_w(3'd0, 16'h0180);
        reg_r(3'd0, v);
        chk("R10 flushed", fs_field(v), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end

endmodule